// File: doc/BRIEF.md
# Streaming Bilinear Pixel Interpolator

This block produces one resized output pixel from a 2×2 neighbourhood of source pixels. Each neighbourhood is split into a vertical stage and a horizontal stage. Source pixels arrive one column at a time: each valid strobe brings the upper and lower pixel of one column, the vertical weight for that column, and the horizontal weight for the output that the column completes. The block first blends the upper and lower pixel of the column with the vertical weight. It then blends the previous column's vertical value with the current one using the horizontal weight.

Each column's vertical value is computed only once. It serves as the right-hand term of the output it completes, and it is then held as the left-hand term of the next output. So the datapath needs one multiplier for the vertical blend and one for the horizontal blend. The first column after reset has no left neighbour and produces no output. After that, every accepted column yields one output a fixed four clock cycles later. Input strobes may come back to back or with idle cycles between them.

Top module: `bilerp_top`

## Requirements
- R1: With a vertical weight of 0 on both columns and a horizontal weight of 0, the output equals the upper pixel of the left column exactly.
- R2: The vertical value of a column with upper pixel T, lower pixel L and weight dy (units of 1/2^FRAC_W) is T + floor(((L − T)·dy + 2^(FRAC_W−1)) / 2^FRAC_W), with the difference taken as a signed value.
- R3: The output is A + floor(((B − A)·dx + 2^(FRAC_W−1)) / 2^FRAC_W). A is the vertical value of the previously accepted column, B is that of the current column, and dx is the horizontal weight presented with the current column.
- R4: An output strobe appears exactly four clock cycles after the input strobe of the column that completes it.
- R5: After reset, the first accepted column produces no output strobe. Every later column produces exactly one output strobe.
- R6: Every output lies between the two vertical values it blends, and is limited to the range 0 to 2^PIX_W − 1.
- R7: While reset is asserted (rst_n low, asynchronous), out_valid and out_pix are 0, and the column history is cleared.
- R8: Idle cycles between input strobes do not change the held left-hand column value.
- R9: Back-to-back input strobes give one output per cycle, with no lost or duplicated outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Column strobe |
| in_top | input | PIX_W | Upper source pixel of the column |
| in_bot | input | PIX_W | Lower source pixel of the column |
| in_dy | input | FRAC_W | Vertical weight for this column |
| in_dx | input | FRAC_W | Horizontal weight for the output this column completes |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | PIX_W | Interpolated pixel |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, 8-bit weights and saturation enabled. With these widths, the bench can drive full-scale weights of 255 against full-range pixel steps of 0 to 255 in both directions. These cases reach the largest products and the rounding behaviour on negative differences. Short weight words also keep every interior weight value cheap to hit, so negative and positive midpoint rounding is exercised directly against the integer formula.

// File: rtl/bilerp_pkg.sv
package bilerp_pkg;
  localparam int DEF_PIX_W  = 8;
  localparam int DEF_FRAC_W = 8;
  localparam int PIPE_DEPTH = 4;
endpackage

// File: rtl/bil_lerp.sv
module bil_lerp #(
  parameter int PIX_W    = bilerp_pkg::DEF_PIX_W,
  parameter int FRAC_W   = bilerp_pkg::DEF_FRAC_W,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic [PIX_W-1:0]        base,
  input  logic signed [PIX_W:0]   diff,
  input  logic [FRAC_W-1:0]       w,
  output logic [PIX_W-1:0]        res
);
  localparam int PW = PIX_W + FRAC_W + 3;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W - 1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] sum;

  always_comb begin
    prod = PW'(diff) * $signed(PW'({1'b0, w}));
    rnd  = prod + HALF;
    sum  = (rnd >>> FRAC_W) + $signed(PW'({1'b0, base}));
  end

  generate
    if (CLAMP_EN) begin : g_sat
      always_comb begin
        if (sum[PW-1])
          res = '0;
        else if (|sum[PW-2:PIX_W])
          res = '1;
        else
          res = sum[PIX_W-1:0];
      end
    end else begin : g_wrap
      always_comb res = sum[PIX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bil_col_hold.sv
module bil_col_hold #(
  parameter int PIX_W    = bilerp_pkg::DEF_PIX_W,
  parameter int FRAC_W   = bilerp_pkg::DEF_FRAC_W,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_vld,
  input  logic [PIX_W-1:0]        s1_top,
  input  logic signed [PIX_W:0]   s1_diff,
  input  logic [FRAC_W-1:0]       s1_dy,
  input  logic [FRAC_W-1:0]       s1_dx,
  output logic                    s2_vld,
  output logic [PIX_W-1:0]        s2_a,
  output logic [PIX_W-1:0]        s2_b,
  output logic [FRAC_W-1:0]       s2_dx
);
  logic [PIX_W-1:0] vert;
  logic             have_prev_q, have_prev_d;
  logic [PIX_W-1:0] prev_q, prev_d;
  logic             vld_d;
  logic [PIX_W-1:0] a_d, b_d;
  logic [FRAC_W-1:0] dx_d;

  bil_lerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .CLAMP_EN(CLAMP_EN)) u_vlerp (
    .base (s1_top),
    .diff (s1_diff),
    .w    (s1_dy),
    .res  (vert)
  );

  always_comb begin
    vld_d       = s1_vld & have_prev_q;
    a_d         = prev_q;
    b_d         = vert;
    dx_d        = s1_dx;
    prev_d      = vert;
    have_prev_d = have_prev_q | s1_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld      <= 1'b0;
      s2_a        <= '0;
      s2_b        <= '0;
      s2_dx       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      s2_vld      <= vld_d;
      have_prev_q <= have_prev_d;
      if (s1_vld) begin
        s2_a   <= a_d;
        s2_b   <= b_d;
        s2_dx  <= dx_d;
        prev_q <= prev_d;
      end
    end
  end

  logic [PIX_W:0] top_x, bot_x, lo_x, hi_x;
  always_comb begin
    top_x = {1'b0, s1_top};
    bot_x = top_x + s1_diff;
    lo_x  = (top_x < bot_x) ? top_x : bot_x;
    hi_x  = (top_x < bot_x) ? bot_x : top_x;
  end

  assert_vert_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> ({1'b0, vert} >= lo_x && {1'b0, vert} <= hi_x));

  assert_first_col_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(have_prev_q) |-> !s2_vld);
endmodule

// File: rtl/bil_out_stage.sv
module bil_out_stage #(
  parameter int PIX_W    = bilerp_pkg::DEF_PIX_W,
  parameter int FRAC_W   = bilerp_pkg::DEF_FRAC_W,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s3_vld,
  input  logic [PIX_W-1:0]        s3_a,
  input  logic signed [PIX_W:0]   s3_h,
  input  logic [FRAC_W-1:0]       s3_dx,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix
);
  logic [PIX_W-1:0] pix_d;

  bil_lerp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .CLAMP_EN(CLAMP_EN)) u_hlerp (
    .base (s3_a),
    .diff (s3_h),
    .w    (s3_dx),
    .res  (pix_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s3_vld;
      if (s3_vld)
        out_pix <= pix_d;
    end
  end
endmodule

// File: rtl/bilerp_top.sv
module bilerp_top #(
  parameter int PIX_W    = bilerp_pkg::DEF_PIX_W,
  parameter int FRAC_W   = bilerp_pkg::DEF_FRAC_W,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_top,
  input  logic [PIX_W-1:0]  in_bot,
  input  logic [FRAC_W-1:0] in_dy,
  input  logic [FRAC_W-1:0] in_dx,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int DIFF_W = PIX_W + 1;

  // stage 1: column difference
  logic                     s1_vld;
  logic [PIX_W-1:0]         s1_top;
  logic signed [DIFF_W-1:0] s1_diff, s1_diff_d;
  logic [FRAC_W-1:0]        s1_dy, s1_dx;

  always_comb s1_diff_d = $signed({1'b0, in_bot}) - $signed({1'b0, in_top});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_top  <= '0;
      s1_diff <= '0;
      s1_dy   <= '0;
      s1_dx   <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_top  <= in_top;
        s1_diff <= s1_diff_d;
        s1_dy   <= in_dy;
        s1_dx   <= in_dx;
      end
    end
  end

  // stage 2: vertical blend and column history
  logic              s2_vld;
  logic [PIX_W-1:0]  s2_a, s2_b;
  logic [FRAC_W-1:0] s2_dx;

  bil_col_hold #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .CLAMP_EN(CLAMP_EN)) u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_top  (s1_top),
    .s1_diff (s1_diff),
    .s1_dy   (s1_dy),
    .s1_dx   (s1_dx),
    .s2_vld  (s2_vld),
    .s2_a    (s2_a),
    .s2_b    (s2_b),
    .s2_dx   (s2_dx)
  );

  // stage 3: horizontal difference
  logic                     s3_vld;
  logic [PIX_W-1:0]         s3_a;
  logic signed [DIFF_W-1:0] s3_h, s3_h_d;
  logic [FRAC_W-1:0]        s3_dx;

  always_comb s3_h_d = $signed({1'b0, s2_b}) - $signed({1'b0, s2_a});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_vld <= 1'b0;
      s3_a   <= '0;
      s3_h   <= '0;
      s3_dx  <= '0;
    end else begin
      s3_vld <= s2_vld;
      if (s2_vld) begin
        s3_a  <= s2_a;
        s3_h  <= s3_h_d;
        s3_dx <= s2_dx;
      end
    end
  end

  // stage 4: horizontal blend
  bil_out_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .CLAMP_EN(CLAMP_EN)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .s3_vld    (s3_vld),
    .s3_a      (s3_a),
    .s3_h      (s3_h),
    .s3_dx     (s3_dx),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  // bounds of the two column values feeding stage 4
  logic [DIFF_W-1:0] s3_ax, s3_bx, s3_lo, s3_hi;
  always_comb begin
    s3_ax = {1'b0, s3_a};
    s3_bx = s3_ax + s3_h;
    s3_lo = (s3_ax < s3_bx) ? s3_ax : s3_bx;
    s3_hi = (s3_ax < s3_bx) ? s3_bx : s3_ax;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  assert_out_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_pix} >= $past(s3_lo) && {1'b0, out_pix} <= $past(s3_hi)));

  assert_dx_zero_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(s3_dx) == '0) |-> out_pix == $past(s3_a));

  assert_s2_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(s2_b));
endmodule

// File: tb/sim_bilerp_top.sv
module sim_bilerp_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_top = '0, in_bot = '0, in_dy = '0, in_dx = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  always #4 clk = ~clk;

  bilerp_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_top(in_top), .in_bot(in_bot), .in_dy(in_dy), .in_dx(in_dx),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int seen = 0;
  int prev_v = 0;
  bit have_prev = 0;
  int    q_pix[$];
  int    q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int rnd_blend(input int base, input int other, input int w);
    int r;
    r = base + ((((other - base) * w) + 128) >>> 8);
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  // monitor: values and four-cycle latency (R4)
  always @(negedge clk) begin
    if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      check(0, {q_tag[0], "/R4 missing"}, 0, 1);
      void'(q_pix.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
    end
    if (out_valid) begin
      seen++;
      if (q_cyc.size() == 0) begin
        check(0, "R5 unexpected output", out_pix, -1);
      end else begin
        check(q_cyc[0] == cyc, {q_tag[0], "/R4 latency"}, cyc, q_cyc[0]);
        check(out_pix == 8'(q_pix[0]), q_tag[0], out_pix, q_pix[0]);
        void'(q_pix.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic drive_col(input int t, input int b, input int dy, input int dx, input string tag);
    int v;
    @(negedge clk);
    in_valid = 1'b1;
    in_top = 8'(t); in_bot = 8'(b); in_dy = 8'(dy); in_dx = 8'(dx);
    v = rnd_blend(t, b, dy);
    if (have_prev) begin
      q_pix.push_back(rnd_blend(prev_v, v, dx));
      q_cyc.push_back(cyc + 4);
      q_tag.push_back(tag);
    end
    prev_v = v;
    have_prev = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_top = 8'hA5; in_bot = 8'h5A; in_dy = 8'h33; in_dx = 8'hCC;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    have_prev = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    check(out_pix == 8'd0, "R7 out_pix in reset", out_pix, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset();
    idle(2);
    check(out_valid == 1'b0, "R7 idle after reset", out_valid, 0);
  endtask

  task automatic t_first_col;
    int s0;
    s0 = seen;
    drive_col(90, 10, 64, 0, "R5 first");
    idle(8);
    check(seen == s0, "R5 first column quiet", seen - s0, 0);
    drive_col(200, 100, 0, 0, "R5 second");
    idle(6);
    check(seen == s0 + 1, "R5 second column output", seen - s0, 1);
  endtask

  task automatic t_zero_weights;
    drive_col(17, 240, 0, 0, "R1 setup");
    drive_col(3, 250, 0, 0, "R1 left-top exact");
    drive_col(255, 0, 0, 0, "R1 left-top exact");
    idle(6);
  endtask

  task automatic t_vertical;
    drive_col(10, 20, 128, 0, "R2 vert up");
    drive_col(200, 20, 77, 0, "R2 vert down");
    drive_col(0, 255, 255, 0, "R2 vert full");
    drive_col(255, 0, 1, 0, "R2 vert neg tiny");
    drive_col(7, 8, 128, 0, "R2 vert half");
    idle(6);
  endtask

  task automatic t_horizontal;
    drive_col(0, 0, 0, 0, "R3 setup");
    drive_col(255, 255, 0, 128, "R3 half");
    drive_col(0, 0, 0, 255, "R3 down full");
    drive_col(100, 50, 200, 64, "R3 mixed");
    drive_col(33, 199, 3, 129, "R3 mixed2");
    idle(6);
  endtask

  task automatic t_extremes;
    drive_col(0, 255, 255, 255, "R6 extremes");
    drive_col(255, 0, 255, 255, "R6 extremes");
    drive_col(255, 255, 255, 255, "R6 saturate top");
    drive_col(0, 0, 128, 1, "R6 floor");
    idle(6);
  endtask

  task automatic t_gaps;
    drive_col(40, 80, 100, 10, "R8 gap");
    idle(1);
    drive_col(120, 60, 30, 200, "R8 gap 1");
    idle(3);
    drive_col(5, 250, 170, 90, "R8 gap 3");
    idle(2);
    drive_col(66, 66, 12, 0, "R8 gap 2");
    idle(6);
  endtask

  task automatic t_stream;
    int s0;
    s0 = seen;
    for (int k = 0; k < 12; k++)
      drive_col((k * 37) % 256, (k * 91 + 13) % 256, (k * 23) % 256, (k * 59 + 7) % 256, "R9 stream");
    idle(6);
    check(seen == s0 + 12, "R9 stream count", seen - s0, 12);
  endtask

  task automatic t_midreset;
    int s0;
    drive_col(9, 9, 0, 0, "R7 pre");
    idle(6);
    do_reset();
    s0 = seen;
    drive_col(100, 100, 0, 0, "R7 first after reset");
    idle(6);
    check(seen == s0, "R7 history cleared", seen - s0, 0);
    drive_col(50, 150, 128, 128, "R7 second after reset");
    idle(6);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_first_col();
    t_zero_weights();
    t_vertical();
    t_horizontal();
    t_extremes();
    t_gaps();
    t_stream();
    t_midreset();
    idle(4);
    check(q_cyc.size() == 0, "R4 all outputs delivered", q_cyc.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule